// File: doc/BRIEF.md
# Event Configuration Sequencer

This block turns system events into short board-configuration scripts. A byte table, read through a simple synchronous read port, holds sections. Each section opens with an event identifier and lists commands to run when that event occurs. The commands drive one of eight general-purpose output pins high or low, pause for a number of millisecond ticks, or hand a three-byte register write (device address, register number, value) to an external two-wire bus master. The bus bit engine and the table storage are outside the block.

Events enter through a valid/ready interface into a small queue. They are handled one at a time in arrival order. When a script is asked for, the sequencer walks the table from address zero, skips over the argument bytes of bus writes, and runs the first matching section until it reaches the next event identifier or the end byte. After reset the block reads table byte zero once. If that byte is the end byte, the loaded table counts as empty and a built-in default table is used in its place until the next reset. Otherwise only the loaded table is consulted. The initialisation event then runs once.

Top module: `evt_cfg_sequencer`

## Requirements
- R1: During reset `gpio` is 0x00 and `i2c_valid` and `evt_ovf` are low. After reset, the initialisation event 0x18 is run once from the active table without being queued, and `busy` stays high until that script has ended.
- R2: In the table, an even byte below 0xD0 is an event identifier and 0xFE ends the table. A section's commands run in table order and stop at the next event identifier or at 0xFE. When several sections share an identifier, only the first one runs.
- R3: Even opcodes 0xD0–0xDE drive pin n low and even opcodes 0xE0–0xEE drive pin n high, where n is opcode bits 3:1. Other pins are left unchanged.
- R4: Opcodes 0xF0, 0xF2 and 0xF4 pause the script until 1, 10 or 100 `ms_tick` pulses have been seen after the pause starts. The command after the pause takes effect only after the last of those pulses.
- R5: An odd byte below 0xD0 is the device byte of a bus write, and the next two bytes are the register and the value. These two argument bytes are never decoded as opcodes or event identifiers, neither while a script runs nor while the table is searched.
- R6: A bus write is offered on `i2c_valid` with `i2c_dev`, `i2c_reg` and `i2c_val`. All of these hold steady until a cycle in which `i2c_ready` is high. The script then continues. Each command produces exactly one transfer.
- R7: Unknown opcodes are skipped without any effect, and the script continues with the next byte. Unknown opcodes are odd bytes from 0xD0 upward, 0xF6–0xFD and 0xFF.
- R8: Built-in default table, in use only when byte 0 was 0xFE at reset. Event 0x14 sets pin 0 and event 0x16 clears it. Event 0x1A sets pin 1 and 0x1C clears it. Event 0x1E sets pin 2 and 0x20 clears it. Event 0x22 sets pin 4 and 0x24 clears it.
- R9: Default rate events. Events 0x00, 0x02, 0x04 and 0x06 belong to the 48 kHz family and events 0x08, 0x0A, 0x0C and 0x0E to the 44.1 kHz family. Each sets pin 3 high for the 48 kHz family and low for the other. Pin 5 is set from identifier bit 2 and pin 4 from identifier bit 1, which together form the rate index.
- R10: When byte 0 of the loaded table is not 0xFE, the default table is never used. An event with no section in the loaded table leaves the pins unchanged, even if the default table would have acted on it.
- R11: Accepted events run in arrival order. `evt_ready` is low exactly when the queue is full. An event offered while `evt_ready` is low is dropped and sets `evt_ovf`, which stays high until reset.
- R12: `busy` is high from the cycle after an event is accepted until its script and all queued events are done. An event with no matching section ends with no effect on the pins or the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Queue can accept an event |
| evt_id | input | 7 | Event identifier |
| evt_ovf | output | 1 | Sticky flag: an event was dropped |
| tbl_addr | output | ADDR_W | Table byte address |
| tbl_data | input | 8 | Table byte; it must be the byte at the `tbl_addr` of the previous cycle |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| gpio | output | 8 | Output pin levels |
| i2c_valid | output | 1 | Bus write request |
| i2c_ready | input | 1 | Bus master takes the request |
| i2c_dev | output | 8 | Device byte as stored in the table |
| i2c_reg | output | 8 | Register number |
| i2c_val | output | 8 | Value to write |
| busy | output | 1 | A script is running or events are queued |

## Verification
Because the search and the script walk share one address pointer, a wrong internal position usually shows at the ports within a few table bytes. It can appear as a bus write whose fields come from a shifted position, or as a pin flip taken from an argument byte. A mistaken search can also end a script early, and the scoreboard or the next pin check then reports it. A wrong table-source decision at reset shows when the first event completes, because a loaded table and the default table give different pin results. A pause counter that is off by one pulse shows as a pin changing one tick early or late.

// File: rtl/evtseq_pkg.sv
package evtseq_pkg;

  localparam logic [7:0] END_BYTE = 8'hFE;
  localparam logic [7:0] INIT_EVT = 8'h18;

  typedef enum logic [2:0] {
    K_END, K_EVT, K_PIN_LO, K_PIN_HI, K_WAIT, K_I2C, K_SKIP
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_DEC, ST_DLY, ST_I2C
  } state_e;

  typedef enum logic [1:0] {
    M_PROBE, M_SCAN, M_EXEC, M_ARG
  } mode_e;

  // decides what a table byte means by its value range
  function automatic kind_e classify(input logic [7:0] b);
    kind_e k;
    if (b == END_BYTE)                       k = K_END;
    else if (b < 8'hD0)                      k = b[0] ? K_I2C : K_EVT;
    else if (b[7:4] == 4'hD && !b[0])        k = K_PIN_LO;
    else if (b[7:4] == 4'hE && !b[0])        k = K_PIN_HI;
    else if (b == 8'hF0 || b == 8'hF2 || b == 8'hF4) k = K_WAIT;
    else                                     k = K_SKIP;
    return k;
  endfunction

  function automatic logic [6:0] wait_len(input logic [7:0] b);
    logic [6:0] n;
    case (b)
      8'hF0:   n = 7'd1;
      8'hF2:   n = 7'd10;
      default: n = 7'd100;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/evtseq_fifo.sv
module evtseq_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CAP);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) store[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/evtseq_dflt_rom.sv
module evtseq_dflt_rom #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        q
);

  localparam int LO_W = 6;

  logic [7:0]      b;
  logic [LO_W-1:0] lo;
  logic            hi_zero;
  logic [2:0]      k;
  logic            fam48;

  assign lo      = addr[LO_W-1:0];
  assign hi_zero = (addr[ADDR_W-1:LO_W] == '0);
  assign k       = lo[4:2];
  assign fam48   = !k[2];

  // rate sections occupy bytes 0..31, four bytes each;
  // single-pin sections occupy 32..47, two bytes each
  always_comb begin
    b = 8'hFE;
    if (hi_zero && !lo[5]) begin
      case (lo[1:0])
        2'd0:    b = {4'h0, k, 1'b0};
        2'd1:    b = {fam48 ? 4'hE : 4'hD, 4'h6};
        2'd2:    b = {k[1] ? 4'hE : 4'hD, 4'hA};
        default: b = {k[0] ? 4'hE : 4'hD, 4'h8};
      endcase
    end else if (hi_zero && lo[5:4] == 2'b10) begin
      if (!lo[0]) begin
        case (lo[3:1])
          3'd0:    b = 8'h14;
          3'd1:    b = 8'h16;
          3'd2:    b = 8'h1A;
          3'd3:    b = 8'h1C;
          3'd4:    b = 8'h1E;
          3'd5:    b = 8'h20;
          3'd6:    b = 8'h22;
          default: b = 8'h24;
        endcase
      end else begin
        case (lo[3:1])
          3'd0:    b = 8'hE0;
          3'd1:    b = 8'hD0;
          3'd2:    b = 8'hE2;
          3'd3:    b = 8'hD2;
          3'd4:    b = 8'hE4;
          3'd5:    b = 8'hD4;
          3'd6:    b = 8'hE8;
          default: b = 8'hD8;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 8'hFE;
    else        q <= b;
  end

endmodule

// File: rtl/evtseq_engine.sv
module evtseq_engine
  import evtseq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [6:0]        q_head,
  output logic              q_pop,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [7:0]        ext_byte,
  input  logic [7:0]        rom_byte,
  input  logic              ms_tick,
  output logic [7:0]        gpio,
  output logic              i2c_valid,
  input  logic              i2c_ready,
  output logic [7:0]        i2c_dev,
  output logic [7:0]        i2c_reg,
  output logic [7:0]        i2c_val,
  output logic              idle
);

  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3);

  state_e            state_q;
  mode_e             mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        target_q;
  logic              use_dflt_q;
  logic [6:0]        dly_q;
  logic              arg_q;
  logic [7:0]        gpio_q, dev_q, reg_q, val_q;
  logic [7:0]        cur;
  kind_e             kind;

  assign cur       = use_dflt_q ? rom_byte : ext_byte;
  assign kind      = classify(cur);
  assign tbl_addr  = addr_q;
  assign q_pop     = (state_q == ST_IDLE) && !q_empty;
  assign idle      = (state_q == ST_IDLE);
  assign gpio      = gpio_q;
  assign i2c_valid = (state_q == ST_I2C);
  assign i2c_dev   = dev_q;
  assign i2c_reg   = reg_q;
  assign i2c_val   = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_RD;
      mode_q     <= M_PROBE;
      addr_q     <= '0;
      target_q   <= INIT_EVT;
      use_dflt_q <= 1'b0;
      dly_q      <= '0;
      arg_q      <= 1'b0;
      gpio_q     <= '0;
      dev_q      <= '0;
      reg_q      <= '0;
      val_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!q_empty) begin
            target_q <= {1'b0, q_head};
            mode_q   <= M_SCAN;
            addr_q   <= '0;
            state_q  <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_DEC;
        ST_DEC: begin
          case (mode_q)
            M_PROBE: begin
              use_dflt_q <= (cur == END_BYTE);
              mode_q     <= M_SCAN;
              addr_q     <= '0;
              state_q    <= ST_RD;
            end
            M_SCAN: begin
              case (kind)
                K_END: state_q <= ST_IDLE;
                K_I2C: begin
                  addr_q  <= addr_q + STEP3;
                  state_q <= ST_RD;
                end
                default: begin
                  if (kind == K_EVT && cur == target_q) mode_q <= M_EXEC;
                  addr_q  <= addr_q + STEP1;
                  state_q <= ST_RD;
                end
              endcase
            end
            M_EXEC: begin
              case (kind)
                K_END, K_EVT: state_q <= ST_IDLE;
                K_PIN_LO: begin
                  gpio_q[cur[3:1]] <= 1'b0;
                  addr_q  <= addr_q + STEP1;
                  state_q <= ST_RD;
                end
                K_PIN_HI: begin
                  gpio_q[cur[3:1]] <= 1'b1;
                  addr_q  <= addr_q + STEP1;
                  state_q <= ST_RD;
                end
                K_WAIT: begin
                  dly_q   <= wait_len(cur);
                  addr_q  <= addr_q + STEP1;
                  state_q <= ST_DLY;
                end
                K_I2C: begin
                  dev_q   <= cur;
                  arg_q   <= 1'b0;
                  mode_q  <= M_ARG;
                  addr_q  <= addr_q + STEP1;
                  state_q <= ST_RD;
                end
                default: begin
                  addr_q  <= addr_q + STEP1;
                  state_q <= ST_RD;
                end
              endcase
            end
            default: begin
              addr_q <= addr_q + STEP1;
              if (!arg_q) begin
                reg_q   <= cur;
                arg_q   <= 1'b1;
                state_q <= ST_RD;
              end else begin
                val_q   <= cur;
                state_q <= ST_I2C;
              end
            end
          endcase
        end
        ST_DLY: begin
          if (ms_tick) begin
            dly_q <= dly_q - 7'd1;
            if (dly_q == 7'd1) state_q <= ST_RD;
          end
        end
        ST_I2C: begin
          if (i2c_ready) begin
            mode_q  <= M_EXEC;
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evt_cfg_sequencer.sv
module evt_cfg_sequencer #(
  parameter int ADDR_W = 10,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [6:0]        evt_id,
  output logic              evt_ovf,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [7:0]        tbl_data,
  input  logic              ms_tick,
  output logic [7:0]        gpio,
  output logic              i2c_valid,
  input  logic              i2c_ready,
  output logic [7:0]        i2c_dev,
  output logic [7:0]        i2c_reg,
  output logic [7:0]        i2c_val,
  output logic              busy
);

  logic       q_full, q_empty, q_pop, eng_idle, ovf_q;
  logic [6:0] q_head;
  logic [7:0] rom_byte;

  assign evt_ready = !q_full;
  assign evt_ovf   = ovf_q;
  assign busy      = !eng_idle || !q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)                       ovf_q <= 1'b0;
    else if (evt_valid && !evt_ready) ovf_q <= 1'b1;
  end

  evtseq_fifo #(.W(7), .DEPTH(QDEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (evt_valid),
    .din   (evt_id),
    .pop   (q_pop),
    .dout  (q_head),
    .full  (q_full),
    .empty (q_empty)
  );

  evtseq_dflt_rom #(.ADDR_W(ADDR_W)) u_dflt (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (tbl_addr),
    .q     (rom_byte)
  );

  evtseq_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_empty   (q_empty),
    .q_head    (q_head),
    .q_pop     (q_pop),
    .tbl_addr  (tbl_addr),
    .ext_byte  (tbl_data),
    .rom_byte  (rom_byte),
    .ms_tick   (ms_tick),
    .gpio      (gpio),
    .i2c_valid (i2c_valid),
    .i2c_ready (i2c_ready),
    .i2c_dev   (i2c_dev),
    .i2c_reg   (i2c_reg),
    .i2c_val   (i2c_val),
    .idle      (eng_idle)
  );

endmodule

// File: rtl/evtseq_chk.sv
module evtseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic       evt_ready,
  input logic       evt_ovf,
  input logic [7:0] gpio,
  input logic       i2c_valid,
  input logic       i2c_ready,
  input logic [7:0] i2c_dev,
  input logic [7:0] i2c_reg,
  input logic [7:0] i2c_val,
  input logic       busy
);

  // R6
  i2c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_valid && !i2c_ready |=> i2c_valid && $stable(i2c_dev) && $stable(i2c_reg) && $stable(i2c_val));

  // R6
  i2c_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_valid |-> busy);

  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_ovf);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> evt_ovf);

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready |=> busy);

  // R3
  pin_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio != $past(gpio)) |-> $past(busy));

endmodule

bind evt_cfg_sequencer evtseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_ovf   (evt_ovf),
  .gpio      (gpio),
  .i2c_valid (i2c_valid),
  .i2c_ready (i2c_ready),
  .i2c_dev   (i2c_dev),
  .i2c_reg   (i2c_reg),
  .i2c_val   (i2c_val),
  .busy      (busy)
);

// File: tb/test_evt_cfg_sequencer.sv
module test_evt_cfg_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic       evt_ready;
  logic [6:0] evt_id = '0;
  logic       evt_ovf;
  logic [9:0] tbl_addr;
  logic [7:0] tbl_data;
  logic       ms_tick = 1'b0;
  logic [7:0] gpio;
  logic       i2c_valid;
  logic       i2c_ready = 1'b0;
  logic [7:0] i2c_dev, i2c_reg, i2c_val;
  logic       busy;

  int checks = 0;
  int errors = 0;
  logic [7:0]  mem [0:1023];
  logic [23:0] expq [$];
  logic [7:0]  exp_g;

  always #2 clk = ~clk;

  always @(posedge clk) tbl_data <= mem[tbl_addr];

  evt_cfg_sequencer i_evt_cfg_sequencer (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_id(evt_id), .evt_ovf(evt_ovf), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .ms_tick(ms_tick), .gpio(gpio), .i2c_valid(i2c_valid), .i2c_ready(i2c_ready),
    .i2c_dev(i2c_dev), .i2c_reg(i2c_reg), .i2c_val(i2c_val), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: drives ready with a back-pressure pattern, pops the scoreboard
  int ncyc = 0;
  bit held = 1'b0;
  logic [23:0] held_v;
  always @(negedge clk) begin
    ncyc++;
    i2c_ready = (ncyc % 3 == 0);
    if (i2c_valid && held)
      chk({i2c_dev, i2c_reg, i2c_val} == held_v, "R6 hold", {i2c_dev, i2c_reg, i2c_val}, held_v);
    held = i2c_valid && !i2c_ready;
    held_v = {i2c_dev, i2c_reg, i2c_val};
    if (i2c_valid && i2c_ready) begin
      if (expq.size() == 0)
        chk(1'b0, "R5 unexpected write", {i2c_dev, i2c_reg, i2c_val}, 0);
      else begin
        logic [23:0] e;
        e = expq.pop_front();
        chk({i2c_dev, i2c_reg, i2c_val} == e, "R5 write", {i2c_dev, i2c_reg, i2c_val}, e);
      end
    end
  end

  task automatic send_evt(input logic [7:0] id);
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    evt_valid = 1'b1;
    evt_id = id[6:0];
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic tick();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] dflt_apply(input logic [7:0] id, input logic [7:0] g);
    logic [7:0] r = g;
    case (id)
      8'h14: r[0] = 1'b1;
      8'h16: r[0] = 1'b0;
      8'h1A: r[1] = 1'b1;
      8'h1C: r[1] = 1'b0;
      8'h1E: r[2] = 1'b1;
      8'h20: r[2] = 1'b0;
      8'h22: r[4] = 1'b1;
      8'h24: r[4] = 1'b0;
      default: if (id < 8'h10 && !id[0]) begin
        r[3] = (id < 8'h08);
        r[5] = id[2];
        r[4] = id[1];
      end
    endcase
    return r;
  endfunction

  initial begin
    int n;
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFE;
    // phase 1: empty loaded table
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(gpio == 8'h00 && !i2c_valid && !evt_ovf, "R1 reset", {gpio, 7'b0, i2c_valid, 7'b0, evt_ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy during init", busy, 1);
    wait_idle();
    exp_g = 8'h00;
    chk(gpio == exp_g, "R1 init default", gpio, exp_g);
    begin
      logic [7:0] seq [14] = '{8'h14, 8'h1A, 8'h1E, 8'h06, 8'h08, 8'h0A, 8'h0C,
                               8'h22, 8'h24, 8'h00, 8'h30, 8'h16, 8'h1C, 8'h20};
      for (int i = 0; i < 14; i++) begin
        send_evt(seq[i]);
        wait_idle();
        exp_g = dflt_apply(seq[i], exp_g);
        if (seq[i] == 8'h30)     chk(gpio == exp_g, "R12 unknown event", gpio, exp_g);
        else if (seq[i] < 8'h10) chk(gpio == exp_g, "R9 rate", gpio, exp_g);
        else                     chk(gpio == exp_g, "R8 default", gpio, exp_g);
      end
    end

    // phase 2: loaded table
    mem[0]  = 8'h18; mem[1]  = 8'h35; mem[2]  = 8'h10; mem[3]  = 8'h01; mem[4] = 8'hE6;
    mem[5]  = 8'h14; mem[6]  = 8'hE0; mem[7]  = 8'hF2; mem[8]  = 8'hE2;
    mem[9]  = 8'h16; mem[10] = 8'hD0; mem[11] = 8'h41; mem[12] = 8'h02; mem[13] = 8'hD4;
    mem[14] = 8'hFB; mem[15] = 8'hEE;
    mem[16] = 8'h04; mem[17] = 8'hE8;
    mem[18] = 8'h06; mem[19] = 8'hD8;
    mem[20] = 8'h04; mem[21] = 8'hEC;
    mem[22] = 8'hFE;
    expq.push_back({8'h35, 8'h10, 8'h01});
    do_reset();
    wait_idle();
    chk(gpio == 8'h08, "R1 init loaded", gpio, 8'h08);
    chk(expq.size() == 0, "R5 init write", expq.size(), 0);

    send_evt(8'h1A); wait_idle();
    chk(gpio == 8'h08, "R10 no default", gpio, 8'h08);
    send_evt(8'h02); wait_idle();
    chk(gpio == 8'h08, "R5 args not events", gpio, 8'h08);

    send_evt(8'h14);
    n = 0;
    while (!gpio[0] && n < 60) begin @(negedge clk); n++; end
    chk(gpio[0] == 1'b1, "R3 pin high", gpio[0], 1);
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R12 busy in pause", busy, 1);
    for (int i = 0; i < 9; i++) tick();
    chk(gpio[1] == 1'b0, "R4 pause not over", gpio[1], 0);
    send_evt(8'h06); send_evt(8'h04); send_evt(8'h30); send_evt(8'h30);
    @(negedge clk);
    chk(evt_ready == 1'b0, "R11 full", evt_ready, 0);
    evt_valid = 1'b1; evt_id = 7'h16;
    @(negedge clk);
    evt_valid = 1'b0;
    @(negedge clk);
    chk(evt_ovf == 1'b1, "R11 overflow", evt_ovf, 1);
    tick();
    repeat (4) @(negedge clk);
    chk(gpio[1] == 1'b1, "R4 pause over", gpio[1], 1);
    wait_idle();
    chk(gpio == 8'h1B, "R11 order", gpio, 8'h1B);

    expq.push_back({8'h41, 8'h02, 8'hD4});
    send_evt(8'h16); wait_idle();
    chk(gpio == 8'h9A, "R7 skip then pin7", gpio, 8'h9A);
    chk(expq.size() == 0, "R6 write taken", expq.size(), 0);
    send_evt(8'h06); wait_idle();
    chk(gpio == 8'h8A, "R2 section 06", gpio, 8'h8A);
    send_evt(8'h04); wait_idle();
    chk(gpio == 8'h9A, "R2 first section only", gpio, 8'h9A);
    chk(evt_ovf == 1'b1, "R11 sticky", evt_ovf, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule